// File: doc/BRIEF.md
# Pipeline Latency Adjustment Unit

This block sits in the decode stage of a dual-issue in-order pipeline. It forms a producer/consumer pair from one issue slot to the next. The older member of the pair is the instruction issued in the most recent valid slot, and its class and base latency are held in a small history register. The younger member is the instruction presented in the current slot. Class codes arrive already decoded.

For every pair, the unit reports three results:
- the effective result latency of the older instruction;
- the number of stall cycles the younger instruction must wait, which applies only when it reads the older one's destination;
- a flag that keeps the two instructions from issuing in the same cycle.

Most pairs pass the base latency through unchanged. A fixed set of class-pair rules raises, lowers or pins the latency. Value-pinning rules win over increment and decrement. A flush input empties the history, so that the next slot forms no pair.

Top module: `lat_adjust_unit`

Class codes used below: NONE=0, FALU=1 (single-precision FP compute), FRSTORE=2 (FP register store), XFER_GR=3 (FPU communication register to general register), XFER_ST=4 (FPU communication register predecrement store), LOAD=5, DSHIFT=6 (dynamic arithmetic/logical shift), LSMOV=7 (load/store move, no FP register), LSFREG=8 (load/store touching an FP register), FDBL=9 (double-precision FP), DOT4=10 (4-element inner product), MXV4=11 (4x4 vector transform), MULT=12 (multiply/multiply-accumulate), ACCST=13 (predecrement store of the accumulator high/low register), ACCLD=14 (load to the accumulator high/low register), MODESW=15 (precision or FP bank switch), TRUNC=16 (single-precision float-to-integer truncate). The load/store group is LOAD, LSMOV, LSFREG and FRSTORE.

## Requirements
- R1: When no older instruction is held (after reset or a flush), when `slot_valid_i` is 0, or when `flush_i` is 1, all three outputs are zero.
- R2: When no pair rule matches, `adj_lat_o` equals the older instruction's base latency.
- R3: `stall_o` equals `adj_lat_o` minus one, saturated at zero, when `slot_dep_i` is 1, and is zero when `slot_dep_i` is 0.
- R4: An older FALU(1), FDBL(9), DOT4(10), MXV4(11) or TRUNC(16) followed by FRSTORE(2), XFER_GR(3) or XFER_ST(4) gives the base latency minus one.
- R5: An older LOAD(5) followed by DSHIFT(6) gives the base latency plus one when `slot_shamt_i` is 1 (shift-amount operand). When `slot_shamt_i` is 0 (data operand), the base latency is kept.
- R6: An older load/store-group instruction (5, 7, 8, 2) with base latency below 3, followed by FDBL(9), DOT4(10) or MXV4(11), gives exactly 3. A base latency of 3 or more is kept.
- R7: An older MULT(12) followed by ACCST(13) gives 5.
- R8: Two consecutive MULT(12) instructions give 2.
- R9: An older ACCLD(14) gives 4 when followed by ACCST(13), and 1 when followed by MULT(12).
- R10: An older MODESW(15) followed by LSFREG(8) or FRSTORE(2) sets `pair_inhibit_o`, whatever `slot_dep_i` is. Any other younger class leaves it clear.
- R11: An older TRUNC(16) followed by XFER_GR(3) gives 1, taking priority over the R4 decrement.
- R12: A flush empties the history. Idle slots (`slot_valid_i`=0) keep the held older instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Clear the pairing history |
| slot_valid_i | input | 1 | An instruction is presented in this slot |
| slot_cls_i | input | CLS_W | Decoded class of the presented (younger) instruction |
| slot_lat_i | input | LAT_W | Base latency of the presented instruction |
| slot_dep_i | input | 1 | Younger instruction reads the older one's destination |
| slot_shamt_i | input | 1 | The read operand is a shift amount (1) or data (0) |
| adj_lat_o | output | LAT_W | Adjusted latency of the older instruction |
| stall_o | output | LAT_W | Stall cycles for the younger instruction |
| pair_inhibit_o | output | 1 | Forbid issuing the pair in the same cycle |

## Verification
Each rule is exercised by setting up its older class in one slot and presenting its younger class in the next. A neighbouring class pair that must not match is then presented, which separates a correct pair decode from one that ignores either side. The same pairs are driven with and without the dependency flag to separate stall gating from the latency path. The shift operand flag is toggled to tell the shift-amount case from the data case. The truncate-then-transfer pair and the truncate-then-store pair show whether pinning outranks the decrement. Idle slots and flushes placed between multiply pairs show whether the history is kept or emptied at the right moments. A zero base latency with a dependency checks the stall saturation.

// File: rtl/lat_adj_pkg.sv
package lat_adj_pkg;

   localparam int CLS_BITS = 5;

   typedef enum logic [CLS_BITS-1:0] {
      C_NONE    = 5'd0,
      C_FALU    = 5'd1,
      C_FRSTORE = 5'd2,
      C_XFER_GR = 5'd3,
      C_XFER_ST = 5'd4,
      C_LOAD    = 5'd5,
      C_DSHIFT  = 5'd6,
      C_LSMOV   = 5'd7,
      C_LSFREG  = 5'd8,
      C_FDBL    = 5'd9,
      C_DOT4    = 5'd10,
      C_MXV4    = 5'd11,
      C_MULT    = 5'd12,
      C_ACCST   = 5'd13,
      C_ACCLD   = 5'd14,
      C_MODESW  = 5'd15,
      C_TRUNC   = 5'd16
   } cls_e;

   // producers whose result drains early into a store / register transfer
   function automatic logic is_fp_compute(cls_e c);
      return c inside {C_FALU, C_FDBL, C_DOT4, C_MXV4, C_TRUNC};
   endfunction

   function automatic logic is_fp_drain(cls_e c);
      return c inside {C_FRSTORE, C_XFER_GR, C_XFER_ST};
   endfunction

   function automatic logic is_ls_group(cls_e c);
      return c inside {C_LOAD, C_LSMOV, C_LSFREG, C_FRSTORE};
   endfunction

   function automatic logic is_heavy_fp(cls_e c);
      return c inside {C_FDBL, C_DOT4, C_MXV4};
   endfunction

   function automatic logic is_ls_fpreg(cls_e c);
      return c inside {C_LSFREG, C_FRSTORE};
   endfunction

endpackage

// File: rtl/lat_hist.sv
module lat_hist
   import lat_adj_pkg::*;
#(
   parameter int LAT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             load_i,
   input  cls_e             cls_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic             held_o,
   output cls_e             cls_o,
   output logic [LAT_W-1:0] lat_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_o <= 1'b0;
         cls_o  <= C_NONE;
         lat_o  <= '0;
      end else if (flush_i) begin
         held_o <= 1'b0;
         cls_o  <= C_NONE;
         lat_o  <= '0;
      end else if (load_i) begin
         held_o <= 1'b1;
         cls_o  <= cls_i;
         lat_o  <= lat_i;
      end
   end

endmodule

// File: rtl/lat_rule_dec.sv
module lat_rule_dec
   import lat_adj_pkg::*;
#(
   parameter int LAT_W         = 4,
   parameter int LS_FLOOR      = 3,
   parameter int MUL_ACCST_LAT = 5,
   parameter int MUL_CHAIN_LAT = 2,
   parameter int ACCLD_ST_LAT  = 4,
   parameter int ACCLD_MUL_LAT = 1,
   parameter int TRUNC_GR_LAT  = 1
) (
   input  cls_e             old_cls_i,
   input  logic [LAT_W-1:0] old_lat_i,
   input  cls_e             yng_cls_i,
   input  logic             shamt_i,
   output logic             pin_en_o,
   output logic [LAT_W-1:0] pin_val_o,
   output logic             inc_en_o,
   output logic             dec_en_o,
   output logic             inhibit_o
);

   localparam logic [LAT_W-1:0] FLOOR_V   = LAT_W'(LS_FLOOR);
   localparam logic [LAT_W-1:0] MUL_ST_V  = LAT_W'(MUL_ACCST_LAT);
   localparam logic [LAT_W-1:0] MUL_MUL_V = LAT_W'(MUL_CHAIN_LAT);
   localparam logic [LAT_W-1:0] LD_ST_V   = LAT_W'(ACCLD_ST_LAT);
   localparam logic [LAT_W-1:0] LD_MUL_V  = LAT_W'(ACCLD_MUL_LAT);
   localparam logic [LAT_W-1:0] TR_GR_V   = LAT_W'(TRUNC_GR_LAT);

   logic ls_short;
   assign ls_short = is_ls_group(old_cls_i) && (old_lat_i < FLOOR_V);

   // value-pinning rules: class pairs are disjoint, order is immaterial
   always_comb begin
      pin_en_o  = 1'b0;
      pin_val_o = '0;
      if (old_cls_i == C_TRUNC && yng_cls_i == C_XFER_GR) begin
         pin_en_o  = 1'b1;
         pin_val_o = TR_GR_V;
      end else if (ls_short && is_heavy_fp(yng_cls_i)) begin
         pin_en_o  = 1'b1;
         pin_val_o = FLOOR_V;
      end else if (old_cls_i == C_MULT && yng_cls_i == C_ACCST) begin
         pin_en_o  = 1'b1;
         pin_val_o = MUL_ST_V;
      end else if (old_cls_i == C_MULT && yng_cls_i == C_MULT) begin
         pin_en_o  = 1'b1;
         pin_val_o = MUL_MUL_V;
      end else if (old_cls_i == C_ACCLD && yng_cls_i == C_ACCST) begin
         pin_en_o  = 1'b1;
         pin_val_o = LD_ST_V;
      end else if (old_cls_i == C_ACCLD && yng_cls_i == C_MULT) begin
         pin_en_o  = 1'b1;
         pin_val_o = LD_MUL_V;
      end
   end

   // relative rules
   assign inc_en_o  = (old_cls_i == C_LOAD) && (yng_cls_i == C_DSHIFT) && shamt_i;
   assign dec_en_o  = is_fp_compute(old_cls_i) && is_fp_drain(yng_cls_i);
   assign inhibit_o = (old_cls_i == C_MODESW) && is_ls_fpreg(yng_cls_i);

endmodule

// File: rtl/lat_calc.sv
module lat_calc #(
   parameter int LAT_W = 4
) (
   input  logic             active_i,
   input  logic             dep_i,
   input  logic [LAT_W-1:0] base_i,
   input  logic             pin_en_i,
   input  logic [LAT_W-1:0] pin_val_i,
   input  logic             inc_en_i,
   input  logic             dec_en_i,
   input  logic             inhibit_i,
   output logic [LAT_W-1:0] adj_o,
   output logic [LAT_W-1:0] stall_o,
   output logic             inhibit_o
);

   localparam logic [LAT_W-1:0] ONE = LAT_W'(1);
   localparam logic [LAT_W-1:0] TOP = {LAT_W{1'b1}};

   logic [LAT_W-1:0] bumped;
   logic [LAT_W-1:0] trimmed;
   logic [LAT_W-1:0] chosen;

   assign bumped  = (base_i == TOP) ? TOP : base_i + ONE;
   assign trimmed = (base_i == '0) ? '0 : base_i - ONE;

   // pinning outranks the relative rules
   always_comb begin
      if (pin_en_i)      chosen = pin_val_i;
      else if (inc_en_i) chosen = bumped;
      else if (dec_en_i) chosen = trimmed;
      else               chosen = base_i;
   end

   assign adj_o     = active_i ? chosen : '0;
   assign stall_o   = (active_i && dep_i && chosen != '0) ? chosen - ONE : '0;
   assign inhibit_o = active_i && inhibit_i;

endmodule

// File: rtl/lat_out_stage.sv
module lat_out_stage #(
   parameter int LAT_W   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LAT_W-1:0] adj_i,
   input  logic [LAT_W-1:0] stall_i,
   input  logic             inhibit_i,
   output logic [LAT_W-1:0] adj_o,
   output logic [LAT_W-1:0] stall_o,
   output logic             inhibit_o
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               adj_o     <= '0;
               stall_o   <= '0;
               inhibit_o <= 1'b0;
            end else begin
               adj_o     <= adj_i;
               stall_o   <= stall_i;
               inhibit_o <= inhibit_i;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_ni;
         assign adj_o      = adj_i;
         assign stall_o    = stall_i;
         assign inhibit_o  = inhibit_i;
      end
   endgenerate

endmodule

// File: rtl/lat_adjust_unit.sv
module lat_adjust_unit
   import lat_adj_pkg::*;
#(
   parameter int CLS_W         = 5,
   parameter int LAT_W         = 4,
   parameter bit REG_OUT       = 1'b0,
   parameter int LS_FLOOR      = 3,
   parameter int MUL_ACCST_LAT = 5,
   parameter int MUL_CHAIN_LAT = 2,
   parameter int ACCLD_ST_LAT  = 4,
   parameter int ACCLD_MUL_LAT = 1,
   parameter int TRUNC_GR_LAT  = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             slot_valid_i,
   input  logic [CLS_W-1:0] slot_cls_i,
   input  logic [LAT_W-1:0] slot_lat_i,
   input  logic             slot_dep_i,
   input  logic             slot_shamt_i,
   output logic [LAT_W-1:0] adj_lat_o,
   output logic [LAT_W-1:0] stall_o,
   output logic             pair_inhibit_o
);

   localparam int LAT_MAX = (1 << LAT_W) - 1;

   // elaboration-time parameter checks
   generate
      if (CLS_W < CLS_BITS) begin : g_bad_cls_w
         $error("lat_adjust_unit: CLS_W too narrow for the class set");
      end
      if (LAT_W < 3) begin : g_bad_lat_w
         $error("lat_adjust_unit: LAT_W must be at least 3");
      end
      if (LS_FLOOR > LAT_MAX || MUL_ACCST_LAT > LAT_MAX || MUL_CHAIN_LAT > LAT_MAX ||
          ACCLD_ST_LAT > LAT_MAX || ACCLD_MUL_LAT > LAT_MAX || TRUNC_GR_LAT > LAT_MAX)
      begin : g_bad_pin
         $error("lat_adjust_unit: a pinned latency does not fit LAT_W");
      end
   endgenerate

   // class normalisation: codes with stray upper bits act as NONE
   cls_e yng_cls;
   generate
      if (CLS_W > CLS_BITS) begin : g_wide_cls
         logic upper_clear;
         assign upper_clear = ~|slot_cls_i[CLS_W-1:CLS_BITS];
         assign yng_cls = upper_clear ? cls_e'(slot_cls_i[CLS_BITS-1:0]) : C_NONE;
      end else begin : g_exact_cls
         assign yng_cls = cls_e'(slot_cls_i[CLS_BITS-1:0]);
      end
   endgenerate

   logic             held;
   cls_e             old_cls;
   logic [LAT_W-1:0] old_lat;

   lat_hist #(.LAT_W(LAT_W)) u_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush_i),
      .load_i  (slot_valid_i),
      .cls_i   (yng_cls),
      .lat_i   (slot_lat_i),
      .held_o  (held),
      .cls_o   (old_cls),
      .lat_o   (old_lat)
   );

   logic             pin_en, inc_en, dec_en, inh_raw;
   logic [LAT_W-1:0] pin_val;

   lat_rule_dec #(
      .LAT_W         (LAT_W),
      .LS_FLOOR      (LS_FLOOR),
      .MUL_ACCST_LAT (MUL_ACCST_LAT),
      .MUL_CHAIN_LAT (MUL_CHAIN_LAT),
      .ACCLD_ST_LAT  (ACCLD_ST_LAT),
      .ACCLD_MUL_LAT (ACCLD_MUL_LAT),
      .TRUNC_GR_LAT  (TRUNC_GR_LAT)
   ) u_rules (
      .old_cls_i (old_cls),
      .old_lat_i (old_lat),
      .yng_cls_i (yng_cls),
      .shamt_i   (slot_shamt_i),
      .pin_en_o  (pin_en),
      .pin_val_o (pin_val),
      .inc_en_o  (inc_en),
      .dec_en_o  (dec_en),
      .inhibit_o (inh_raw)
   );

   logic             active;
   logic [LAT_W-1:0] adj_c, stall_c;
   logic             inh_c;

   assign active = held && slot_valid_i && !flush_i;

   lat_calc #(.LAT_W(LAT_W)) u_calc (
      .active_i  (active),
      .dep_i     (slot_dep_i),
      .base_i    (old_lat),
      .pin_en_i  (pin_en),
      .pin_val_i (pin_val),
      .inc_en_i  (inc_en),
      .dec_en_i  (dec_en),
      .inhibit_i (inh_raw),
      .adj_o     (adj_c),
      .stall_o   (stall_c),
      .inhibit_o (inh_c)
   );

   lat_out_stage #(.LAT_W(LAT_W), .REG_OUT(REG_OUT)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adj_i     (adj_c),
      .stall_i   (stall_c),
      .inhibit_i (inh_c),
      .adj_o     (adj_lat_o),
      .stall_o   (stall_o),
      .inhibit_o (pair_inhibit_o)
   );

endmodule

// File: rtl/lat_adjust_chk.sv
module lat_adjust_chk
   import lat_adj_pkg::*;
#(
   parameter int CLS_W   = 5,
   parameter int LAT_W   = 4,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             flush_i,
   input logic             slot_valid_i,
   input logic [CLS_W-1:0] slot_cls_i,
   input logic [LAT_W-1:0] slot_lat_i,
   input logic             slot_dep_i,
   input logic             slot_shamt_i,
   input logic [LAT_W-1:0] adj_lat_o,
   input logic [LAT_W-1:0] stall_o,
   input logic             pair_inhibit_o
);

   logic issued;
   assign issued = slot_valid_i && !flush_i;

   generate
      if (!REG_OUT) begin : g_props
         // R3
         nodep_nostall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !slot_dep_i |-> stall_o == '0);

         // R12
         flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(flush_i) |-> (adj_lat_o == '0 && stall_o == '0 && !pair_inhibit_o));

         // R8
         mul_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issued && slot_cls_i == CLS_W'(C_MULT) &&
             $past(issued && slot_cls_i == CLS_W'(C_MULT)))
            |-> adj_lat_o == LAT_W'(2));

         // R10
         inhibit_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pair_inhibit_o |-> (slot_valid_i &&
               (slot_cls_i == CLS_W'(C_LSFREG) || slot_cls_i == CLS_W'(C_FRSTORE))));

         // R6
         ls_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issued && (slot_cls_i == CLS_W'(C_FDBL) || slot_cls_i == CLS_W'(C_DOT4) ||
                        slot_cls_i == CLS_W'(C_MXV4)) &&
             $past(issued && slot_cls_i == CLS_W'(C_LSFREG) && slot_lat_i < LAT_W'(3)))
            |-> adj_lat_o == LAT_W'(3));

         // R5
         shift_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (issued && slot_cls_i == CLS_W'(C_DSHIFT) && !slot_shamt_i &&
             $past(issued && slot_cls_i == CLS_W'(C_LOAD)))
            |-> adj_lat_o == $past(slot_lat_i));
      end
   endgenerate

endmodule

bind lat_adjust_unit lat_adjust_chk #(
   .CLS_W   (CLS_W),
   .LAT_W   (LAT_W),
   .REG_OUT (REG_OUT)
) u_lat_adjust_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .flush_i        (flush_i),
   .slot_valid_i   (slot_valid_i),
   .slot_cls_i     (slot_cls_i),
   .slot_lat_i     (slot_lat_i),
   .slot_dep_i     (slot_dep_i),
   .slot_shamt_i   (slot_shamt_i),
   .adj_lat_o      (adj_lat_o),
   .stall_o        (stall_o),
   .pair_inhibit_o (pair_inhibit_o)
);

// File: tb/test_lat_adjust_unit.sv
module test_lat_adjust_unit;
   import lat_adj_pkg::*;

   localparam int CW = 5;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          vld = 1'b0;
   logic [CW-1:0] cls = '0;
   logic [LW-1:0] lat = '0;
   logic          dep = 1'b0;
   logic          sh  = 1'b0;
   logic [LW-1:0] adj;
   logic [LW-1:0] stl;
   logic          inh;

   always #4 clk = ~clk;

   lat_adjust_unit #(.CLS_W(CW), .LAT_W(LW)) i_lat_adjust_unit (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .slot_valid_i(vld),
      .slot_cls_i(cls), .slot_lat_i(lat), .slot_dep_i(dep), .slot_shamt_i(sh),
      .adj_lat_o(adj), .stall_o(stl), .pair_inhibit_o(inh)
   );

   typedef struct {
      int    lat;
      int    stall;
      bit    inh;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // bench-side history model
   bit   m_held = 0;
   int   m_cls  = 0;
   int   m_lat  = 0;

   function automatic exp_t model(int oc, int ol, int yc, bit d, bit s, bit v, bit f, string tag);
      exp_t e;
      int   l;
      e.tag = tag; e.lat = 0; e.stall = 0; e.inh = 0;
      if (!m_held || !v || f) return e;                                   // R1
      l = ol;                                                             // R2
      if (oc == 16 && yc == 3) l = 1;                                     // R11
      else if ((oc == 5 || oc == 7 || oc == 8 || oc == 2) && ol < 3 &&
               (yc == 9 || yc == 10 || yc == 11)) l = 3;                  // R6
      else if (oc == 12 && yc == 13) l = 5;                               // R7
      else if (oc == 12 && yc == 12) l = 2;                               // R8
      else if (oc == 14 && yc == 13) l = 4;                               // R9
      else if (oc == 14 && yc == 12) l = 1;                               // R9
      else if (oc == 5 && yc == 6 && s) l = (ol == 15) ? 15 : ol + 1;     // R5
      else if ((oc == 1 || oc == 9 || oc == 10 || oc == 11 || oc == 16) &&
               (yc == 2 || yc == 3 || yc == 4)) l = (ol == 0) ? 0 : ol - 1; // R4
      e.lat   = l;
      e.stall = (d && l > 0) ? l - 1 : 0;                                 // R3
      e.inh   = (oc == 15) && (yc == 8 || yc == 2);                       // R10
      return e;
   endfunction

   task automatic drive(input cls_e c, input int l, input bit d, input bit s,
                        input bit v, input bit f, input string tag);
      @(posedge clk);
      #1;
      cls = c; lat = LW'(l); dep = d; sh = s; vld = v; flush = f;
      q.push_back(model(m_cls, m_lat, int'(c), d, s, v, f, tag));
      if (f) begin
         m_held = 0; m_cls = 0; m_lat = 0;
      end else if (v) begin
         m_held = 1; m_cls = int'(c); m_lat = l;
      end
   endtask

   // monitor: compare one expected item per cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (int'(adj) != e.lat || int'(stl) != e.stall || inh != e.inh) begin
            errors++;
            $display("FAIL %s: got lat=%0d stall=%0d inh=%0d, expected lat=%0d stall=%0d inh=%0d",
                     e.tag, adj, stl, inh, e.lat, e.stall, e.inh);
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (adj != '0 || stl != '0 || inh != 1'b0) begin
         errors++;
         $display("FAIL R1 reset: got lat=%0d stall=%0d inh=%0d, expected 0 0 0", adj, stl, inh);
      end

      drive(C_NONE,    5, 1, 0, 1, 0, "R1 first slot no history");
      drive(C_NONE,    2, 1, 0, 1, 0, "R2 R3 plain pair with dep");
      drive(C_FALU,    4, 0, 0, 1, 0, "R3 plain pair no dep");
      drive(C_FRSTORE, 1, 1, 0, 1, 0, "R4 fp compute then fp store");
      drive(C_FALU,    4, 0, 0, 1, 0, "R2 store then compute");
      drive(C_XFER_GR, 1, 1, 0, 1, 0, "R4 fp compute then transfer to gr");
      drive(C_LOAD,    2, 0, 0, 1, 0, "R2 setup load");
      drive(C_DSHIFT,  1, 1, 1, 1, 0, "R5 load then shift amount");
      drive(C_LOAD,    2, 0, 0, 1, 0, "R2 setup load again");
      drive(C_DSHIFT,  1, 1, 0, 1, 0, "R5 load then shift data unchanged");
      drive(C_LSFREG,  1, 0, 0, 1, 0, "R2 setup ls fp move");
      drive(C_DOT4,    4, 1, 0, 1, 0, "R6 short ls then inner product");
      drive(C_LOAD,    4, 0, 0, 1, 0, "R2 setup long load");
      drive(C_FDBL,    5, 1, 0, 1, 0, "R6 long ls then double kept");
      drive(C_MULT,    3, 0, 0, 1, 0, "R2 setup multiply");
      drive(C_ACCST,   1, 1, 0, 1, 0, "R7 multiply then acc store");
      drive(C_MULT,    3, 0, 0, 1, 0, "R2 setup multiply chain");
      drive(C_MULT,    3, 1, 0, 1, 0, "R8 multiply chain");
      drive(C_NONE,    0, 0, 0, 0, 0, "R1 idle slot");
      drive(C_MULT,    3, 1, 0, 1, 0, "R12 history held across idle");
      drive(C_ACCLD,   3, 0, 0, 1, 0, "R2 setup acc load");
      drive(C_ACCST,   1, 1, 0, 1, 0, "R9 acc load then acc store");
      drive(C_ACCLD,   3, 0, 0, 1, 0, "R2 setup acc load again");
      drive(C_MULT,    3, 1, 0, 1, 0, "R9 acc load then multiply");
      drive(C_MODESW,  1, 0, 0, 1, 0, "R2 setup mode switch");
      drive(C_LSFREG,  1, 0, 0, 1, 0, "R10 mode switch then ls fp access");
      drive(C_MODESW,  1, 0, 0, 1, 0, "R2 setup mode switch again");
      drive(C_LSMOV,   1, 1, 0, 1, 0, "R10 mode switch then plain ls");
      drive(C_TRUNC,   3, 0, 0, 1, 0, "R2 setup truncate");
      drive(C_XFER_GR, 1, 1, 0, 1, 0, "R11 truncate then transfer pinned");
      drive(C_TRUNC,   3, 0, 0, 1, 0, "R2 setup truncate again");
      drive(C_FRSTORE, 1, 1, 0, 1, 0, "R11 R4 truncate then store decrements");
      drive(C_NONE,    0, 0, 0, 1, 0, "R2 setup zero latency");
      drive(C_NONE,    1, 1, 0, 1, 0, "R3 zero latency stall saturates");
      drive(C_MULT,    3, 1, 0, 1, 1, "R1 R12 flush slot");
      drive(C_MULT,    3, 1, 0, 1, 0, "R12 no pair after flush");
      drive(C_MULT,    3, 1, 0, 1, 0, "R8 pair formed again");

      @(posedge clk);
      #1 vld = 1'b0; dep = 1'b0;
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule